// File: doc/BRIEF.md
# Indexed Palette Lookup Table

This block is a 256-entry colour lookup table for an indexed-colour display path. Each entry holds a 30-bit colour made of three 10-bit channels. Software fills the table through a small synchronous register bus. It first writes the entry number to a selector register. It then writes a packed colour word, or an 8-bit-per-channel colour that the block widens to 10 bits per channel. The entry that is written is always the one the selector currently holds, and data writes never move the selector.

On the pixel side, a code and a plane mask arrive with a valid strobe. The block returns the colour and a matching valid flag one clock later. Codes are always limited to 7 bits, so the upper half of the table can never reach the pixel output. A write from software and a pixel lookup may happen in the same cycle without affecting each other.

Top module: `palette_lut`

## Requirements
- R1: Synchronous active-high reset clears every entry to zero, the selector to zero, and the pixel outputs (colour and valid) to zero.
- R2: A bus write (reg_valid=1, reg_write=1) to slot 0 loads reg_wdata[7:0] into the selector. A read of slot 0 returns the selector in bits 7:0, with zeros above.
- R3: A bus write to slot 1 stores reg_wdata[29:0] at the selected entry. The packing is red in bits 9:0, green in bits 19:10 and blue in bits 29:20. A read of slot 1 returns the selected entry.
- R4: Bits 31:30 of a slot 1 write are ignored, and bits 31:30 of every read are zero.
- R5: A bus write to slot 2 takes an 8-bit red (bits 7:0), green (15:8) and blue (23:16). It widens each channel to 10 bits as {c[7:0], c[7:6]} and stores the result at the selected entry. For example, 0xFF becomes 0x3FF and 0x80 becomes 0x202.
- R6: The pixel colour and pix_out_valid appear on the clock edge after the edge that samples pix_valid. A cycle without pix_valid gives pix_out_valid=0 one cycle later.
- R7: The entry looked up is pix_code & pix_mask & 0x7F. Codes 0x80 to 0xFF therefore never reach entries 0x80 to 0xFF.
- R8: When a table write and a lookup of the same entry share a cycle, the lookup returns the value held before the write. A selector write in the same cycle as a lookup leaves the lookup unchanged.
- R9: Writes to slots 1 and 2 leave the selector unchanged. A cycle with reg_valid=0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Bus access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Slot: 0 selector, 1 packed colour, 2 narrow colour |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from slot and state) |
| pix_valid | input | 1 | Lookup request strobe |
| pix_code | input | 8 | Pixel code |
| pix_mask | input | 8 | Plane mask |
| pix_out_valid | output | 1 | Lookup result valid |
| pix_color | output | 30 | Looked-up colour {blue, green, red} |

## Verification
A bus write takes effect at the clock edge that samples it. Read data is combinational, so the bench drives each read half a cycle after that edge and samples it 1 ns later. A lookup presented before edge N shows its colour and valid flag after edge N. The bench therefore samples the pixel outputs at the falling edge that follows the sampling edge, which matches the single register stage. The same-cycle cases for R8 rely on this: the old colour must be seen at that falling edge, and the new colour only after a second lookup.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int CODE_W   = 8;
    localparam int CH_W     = 10;
    localparam int NARROW_W = 8;
    localparam int BUS_W    = 32;
    localparam int COLOR_W  = 3 * CH_W;
    localparam int EXT_W    = CH_W - NARROW_W;

    typedef struct packed {
        logic [CH_W-1:0] blu;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] red;
    } rgb_t;

    typedef enum logic [1:0] {
        SLOT_SEL    = 2'd0,
        SLOT_COLOR  = 2'd1,
        SLOT_NARROW = 2'd2
    } slot_e;

    function automatic logic [CH_W-1:0] widen_ch(input logic [NARROW_W-1:0] c);
        return {c, c[NARROW_W-1 -: EXT_W]};
    endfunction

    function automatic rgb_t widen_rgb(input logic [3*NARROW_W-1:0] w);
        rgb_t o;
        o.red = widen_ch(w[NARROW_W-1:0]);
        o.grn = widen_ch(w[2*NARROW_W-1:NARROW_W]);
        o.blu = widen_ch(w[3*NARROW_W-1:2*NARROW_W]);
        return o;
    endfunction
endpackage

// File: rtl/pal_regif.sv
module pal_regif
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [1:0]        reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    input  rgb_t              sel_entry,
    output logic [CODE_W-1:0] sel_index,
    output logic              tbl_we,
    output rgb_t              tbl_wdata,
    output logic [BUS_W-1:0]  reg_rdata
);
    slot_e slot;
    logic  wr_cyc;
    logic  sink_unused;

    assign slot        = slot_e'(reg_addr);
    assign wr_cyc      = reg_valid && reg_write;
    assign sink_unused = ^reg_wdata[BUS_W-1:COLOR_W];

    always_ff @(posedge clk) begin
        if (rst)
            sel_index <= '0;
        else if (wr_cyc && slot == SLOT_SEL)
            sel_index <= reg_wdata[CODE_W-1:0];
    end

    always_comb begin
        tbl_we    = 1'b0;
        tbl_wdata = '0;
        if (wr_cyc && slot == SLOT_COLOR) begin
            tbl_we    = 1'b1;
            tbl_wdata = rgb_t'(reg_wdata[COLOR_W-1:0]);
        end else if (wr_cyc && slot == SLOT_NARROW) begin
            tbl_we    = 1'b1;
            tbl_wdata = widen_rgb(reg_wdata[3*NARROW_W-1:0]);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (slot)
            SLOT_SEL:   reg_rdata[CODE_W-1:0]  = sel_index;
            SLOT_COLOR: reg_rdata[COLOR_W-1:0] = sel_entry;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  rgb_t                     wdata,
    input  logic [$clog2(DEPTH)-1:0] sel_addr,
    output rgb_t                     sel_data,
    input  logic [$clog2(DEPTH)-1:0] lk_addr,
    output rgb_t                     lk_data
);
    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign sel_data = mem[sel_addr];
    assign lk_data  = mem[lk_addr];
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
    import pal_pkg::*;
#(
    parameter logic [CODE_W-1:0] CODE_LIMIT = 8'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [CODE_W-1:0] pix_code,
    input  logic [CODE_W-1:0] pix_mask,
    output logic [CODE_W-1:0] lk_addr,
    input  rgb_t              lk_data,
    output logic              out_valid,
    output rgb_t              out_color
);
    assign lk_addr = pix_code & pix_mask & CODE_LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_color <= '0;
        end else begin
            out_valid <= pix_valid;
            if (pix_valid)
                out_color <= lk_data;
        end
    end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import pal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               pix_valid,
    input  logic [7:0]         pix_code,
    input  logic [7:0]         pix_mask,
    output logic               pix_out_valid,
    output logic [29:0]        pix_color
);
    localparam int DEPTH = 1 << CODE_W;

    logic [CODE_W-1:0] cur_index;
    logic [CODE_W-1:0] lk_addr;
    logic              tbl_we;
    rgb_t              tbl_wdata;
    rgb_t              cur_entry;
    rgb_t              lk_data;
    rgb_t              out_color;

    pal_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sel_entry (cur_entry),
        .sel_index (cur_index),
        .tbl_we    (tbl_we),
        .tbl_wdata (tbl_wdata),
        .reg_rdata (reg_rdata)
    );

    pal_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (tbl_we),
        .waddr    (cur_index),
        .wdata    (tbl_wdata),
        .sel_addr (cur_index),
        .sel_data (cur_entry),
        .lk_addr  (lk_addr),
        .lk_data  (lk_data)
    );

    pal_lookup u_lookup (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_code  (pix_code),
        .pix_mask  (pix_mask),
        .lk_addr   (lk_addr),
        .lk_data   (lk_data),
        .out_valid (pix_out_valid),
        .out_color (out_color)
    );

    assign pix_color = out_color;
endmodule

// File: rtl/pal_checker.sv
module pal_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_valid,
    input logic        reg_write,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        pix_valid,
    input logic        pix_out_valid,
    input logic [7:0]  cur_index,
    input logic [29:0] cur_entry
);
    logic sel_wr, col_wr, nar_wr;
    assign sel_wr = reg_valid && reg_write && reg_addr == 2'd0;
    assign col_wr = reg_valid && reg_write && reg_addr == 2'd1;
    assign nar_wr = reg_valid && reg_write && reg_addr == 2'd2;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (cur_index == 8'd0 && !pix_out_valid));

    p_packed_store_r3: assert property (@(posedge clk) disable iff (rst)
        col_wr |=> (cur_entry == $past(reg_wdata[29:0])));

    p_top_bits_zero_r4: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[31:30] == 2'b00);

    p_widen_red_r5: assert property (@(posedge clk) disable iff (rst)
        nar_wr |=> (cur_entry[9:0] == {$past(reg_wdata[7:0]), $past(reg_wdata[7:6])}));

    p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> pix_out_valid);

    p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !pix_out_valid);

    p_index_holds_r9: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(cur_index));
endmodule

bind palette_lut pal_checker u_pal_checker (
    .clk           (clk),
    .rst           (rst),
    .reg_valid     (reg_valid),
    .reg_write     (reg_write),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .pix_valid     (pix_valid),
    .pix_out_valid (pix_out_valid),
    .cur_index     (cur_index),
    .cur_entry     (cur_entry)
);

// File: tb/test_palette_lut.sv
`timescale 1ns/1ps
module test_palette_lut;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;
    // {entry, narrow rgb {b,g,r}, expected packed colour}
    localparam logic [61:0] VEC [NVEC] = '{
        {8'h05, 24'h8000FF, 30'h202003FF},
        {8'h10, 24'hC04001, 30'h30340404},
        {8'h7F, 24'h01FF80, 30'h004FFE02},
        {8'h00, 24'hAA3C7F, 30'h2AA3C1FD}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_code = '0, pix_mask = '0;
    logic        pix_out_valid;
    logic [29:0] pix_color;
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    palette_lut i_palette_lut (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_valid(pix_valid), .pix_code(pix_code), .pix_mask(pix_mask),
        .pix_out_valid(pix_out_valid), .pix_color(pix_color)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    // request before the edge, sample at the following falling edge
    task automatic lookup(input logic [7:0] c, input logic [7:0] m);
        @(negedge clk);
        pix_valid = 1'b1; pix_code = c; pix_mask = m;
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        bus_rd(2'd0, rd); check("R1 index", rd, 32'd0);
        bus_rd(2'd1, rd); check("R1 entry", rd, 32'd0);
        check("R1 out_valid", {31'd0, pix_out_valid}, 32'd0);
        check("R1 color", {2'b0, pix_color}, 32'd0);

        // table walk: R2 select, R5 widen, R3 readback, R6 lookup
        for (int k = 0; k < NVEC; k++) begin
            bus_wr(2'd0, {24'd0, VEC[k][61:54]});
            bus_rd(2'd0, rd); check("R2 index", rd, {24'd0, VEC[k][61:54]});
            bus_wr(2'd2, {8'd0, VEC[k][53:30]});
            bus_rd(2'd1, rd); check("R5 widen", rd, {2'b0, VEC[k][29:0]});
            lookup(VEC[k][61:54], 8'hFF);
            check("R6 valid", {31'd0, pix_out_valid}, 32'd1);
            check("R6 color", {2'b0, pix_color}, {2'b0, VEC[k][29:0]});
        end

        // R6 no request -> no valid
        @(negedge clk);
        check("R6 idle", {31'd0, pix_out_valid}, 32'd0);

        // R3/R4 packed write with top bits set
        bus_wr(2'd0, 32'h20);
        bus_wr(2'd1, 32'hFFFF_FFFF);
        bus_rd(2'd1, rd); check("R4 top bits", rd, 32'h3FFF_FFFF);
        bus_wr(2'd1, 32'h1234_5678);
        bus_rd(2'd1, rd); check("R3 packed", rd, 32'h1234_5678);
        // R9 selector unchanged by data writes
        bus_rd(2'd0, rd); check("R9 index kept", rd, 32'h20);
        // R9 invalid cycle ignored
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0;
        @(negedge clk);
        reg_write = 1'b0;
        bus_rd(2'd1, rd); check("R9 no valid", rd, 32'h1234_5678);
        bus_rd(2'd0, rd); check("R9 index", rd, 32'h20);

        // R7 code limit: write entry 0xFF, look up 0xFF -> entry 0x7F
        bus_wr(2'd0, 32'hFF);
        bus_wr(2'd1, 32'h1111_1111);
        lookup(8'hFF, 8'hFF);
        check("R7 limit", {2'b0, pix_color}, 32'h004FFE02);
        lookup(8'h15, 8'h0F);
        check("R7 mask", {2'b0, pix_color}, 32'h202003FF);

        // R8 write and lookup of same entry in one cycle
        bus_wr(2'd0, 32'h05);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0123;
        pix_valid = 1'b1; pix_code = 8'h05; pix_mask = 8'hFF;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; pix_valid = 1'b0;
        check("R8 old value", {2'b0, pix_color}, 32'h202003FF);
        lookup(8'h05, 8'hFF);
        check("R8 new value", {2'b0, pix_color}, 32'h0000_0123);
        // R8 selector write alongside lookup
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h7F;
        pix_valid = 1'b1; pix_code = 8'h10; pix_mask = 8'hFF;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; pix_valid = 1'b0;
        check("R8 sel+lookup", {2'b0, pix_color}, 32'h30340404);
        bus_rd(2'd0, rd); check("R8 sel taken", rd, 32'h7F);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule